// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM that holds sixty-four 16-bit words. A host drives chip select, a serial clock and a serial data line into it, and reads one serial data line back. Every transaction is framed by chip select. Inside a frame the host sends a start bit, a two-bit opcode and a six-bit word address, MSB first. After that, depending on the opcode, the host either clocks read data out, clocks sixteen data bits in, or sends nothing more.

The serial clock and the data lines are sampled with the system clock. A rising edge of the serial clock, seen while chip select is high, advances the frame by one bit. Programming takes effect at once and needs no busy time. The word array powers up with every word erased, and the write-enable latch powers up cleared. The block is meant for use in system simulation, or as an emulated memory on a board-level prototype.

Top module: `sereep_model`

## Requirements
- R1: After reset, data out is 0, every word reads back as 0xFFFF, and the write-enable latch is cleared.
- R2: Rising serial clock edges that carry data in = 0 before the start bit are ignored. A frame is a 1 start bit, then opcode bits [1:0] MSB first, then address bits [5:0] MSB first.
- R3: With opcode 2'b10 (read), the rising edge that carries the last address bit drives data out to 0. The next 16 rising edges present bits 15 down to 0 of the addressed word.
- R4: With opcode 2'b01 (write), the 16 bits that follow the address (bit 15 first) are stored at the address when the 16th bit arrives, provided writes are enabled.
- R5: With opcode 2'b11 (erase), the addressed word becomes 0xFFFF if writes are enabled.
- R6: Opcode 2'b00 with address bits [5:4] = 2'b11 sets the write-enable latch. With [5:4] = 2'b00 it clears the latch. Address bits [3:0] have no effect for either command.
- R7: Opcode 2'b00 with address bits [5:4] = 2'b10 sets every word to 0xFFFF if writes are enabled.
- R8: Opcode 2'b00 with address bits [5:4] = 2'b01, followed by 16 data bits, writes that value to every word if writes are enabled.
- R9: A write, erase, erase-all or write-all received while the latch is cleared leaves every word unchanged.
- R10: Dropping chip select at any point ends the frame. A write that has not yet received all 16 data bits stores nothing. The next frame begins by waiting for a start bit.
- R11: Data out is 0 at all times other than when read data is being presented, including after the 16th read bit and while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every serial line |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; its rising edges shift bits |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The assertions take two things for granted about the host. First, the serial clock is held at each level for at least one system clock, so that every edge is seen. Second, chip select, data in and the serial clock change only between system clock edges. The stimulus changes all inputs on the falling system clock edge, and it holds the serial clock high for one full cycle and low for one full cycle on every bit. Chip select rises and falls only while the serial clock is low, so a frame boundary never coincides with a shifting edge.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    FR_WAIT  = 3'd0,
    FR_HEAD  = 3'd1,
    FR_SHOUT = 3'd2,
    FR_SHIN  = 3'd3,
    FR_SPENT = 3'd4
  } frame_state_e;

  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_STORE   = 2'b01;
  localparam logic [1:0] OPC_FETCH   = 2'b10;
  localparam logic [1:0] OPC_CLEAR   = 2'b11;

  localparam logic [1:0] SUB_LOCK    = 2'b00;
  localparam logic [1:0] SUB_FILL    = 2'b01;
  localparam logic [1:0] SUB_WIPE    = 2'b10;
  localparam logic [1:0] SUB_UNLOCK  = 2'b11;
endpackage

// File: rtl/sereep_array.sv
module sereep_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_all,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = wr_en & (wr_all | (wr_addr == AW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '1;
      else if (hit) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/sereep_frame.sv
module sereep_frame
  import sereep_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          wr_en,
  output logic          wr_all,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wen_o
);
  localparam int HW = 2 + AW;
  localparam int CMAX = (HW > DW) ? HW : DW;
  localparam int CW = $clog2(CMAX + 1);

  frame_state_e  st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] hdr_q, hdr_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] adr_q, adr_d;
  logic          do_q, do_d;
  logic          wen_q, wen_d;
  logic          all_q, all_d;
  logic          sck_q;

  logic          rise;
  logic [HW-1:0] hdr_full;
  logic [1:0]    opc;
  logic [1:0]    sub;
  logic [DW-1:0] sh_in;

  assign rise     = cs_i & sck_i & ~sck_q;
  assign hdr_full = {hdr_q[HW-2:0], sdi_i};
  assign opc      = hdr_full[HW-1:AW];
  assign sub      = hdr_full[AW-1:AW-2];
  assign sh_in    = {sh_q[DW-2:0], sdi_i};
  assign rd_addr  = hdr_full[AW-1:0];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    sh_d    = sh_q;
    adr_d   = adr_q;
    do_d    = do_q;
    wen_d   = wen_q;
    all_d   = all_q;
    wr_en   = 1'b0;
    wr_all  = 1'b0;
    wr_addr = adr_q;
    wr_data = '1;
    if (!cs_i) begin
      st_d  = FR_WAIT;
      cnt_d = '0;
      do_d  = 1'b0;
    end else if (rise) begin
      unique case (st_q)
        FR_WAIT: begin
          if (sdi_i) begin
            st_d  = FR_HEAD;
            cnt_d = '0;
            hdr_d = '0;
          end
        end
        FR_HEAD: begin
          hdr_d = hdr_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(HW - 1)) begin
            cnt_d = '0;
            adr_d = hdr_full[AW-1:0];
            st_d  = FR_SPENT;
            unique case (opc)
              OPC_FETCH: begin
                st_d = FR_SHOUT;
                sh_d = rd_data;
                do_d = 1'b0;
              end
              OPC_STORE: begin
                st_d  = FR_SHIN;
                all_d = 1'b0;
              end
              OPC_CLEAR: begin
                wr_en   = wen_q;
                wr_addr = hdr_full[AW-1:0];
              end
              default: begin
                unique case (sub)
                  SUB_UNLOCK: wen_d = 1'b1;
                  SUB_LOCK:   wen_d = 1'b0;
                  SUB_WIPE: begin
                    wr_en  = wen_q;
                    wr_all = 1'b1;
                  end
                  default: begin
                    st_d  = FR_SHIN;
                    all_d = 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
        FR_SHOUT: begin
          do_d = sh_q[DW-1];
          sh_d = {sh_q[DW-2:0], 1'b0};
        end
        FR_SHIN: begin
          sh_d  = sh_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) begin
            wr_en   = wen_q;
            wr_all  = all_q;
            wr_data = sh_in;
            st_d    = FR_SPENT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_WAIT;
      cnt_q <= '0;
      hdr_q <= '0;
      sh_q  <= '0;
      adr_q <= '0;
      do_q  <= 1'b0;
      wen_q <= 1'b0;
      all_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hdr_q <= hdr_d;
      sh_q  <= sh_d;
      adr_q <= adr_d;
      do_q  <= do_d;
      wen_q <= wen_d;
      all_q <= all_d;
      sck_q <= sck_i;
    end
  end

  assign sdo_o = do_q;
  assign wen_o = wen_q;
endmodule

// File: rtl/sereep_model.sv
module sereep_model #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          wr_en;
  logic          wr_all;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sereep_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_i    (cs_i),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .sdo_o   (sdo_o),
    .wr_en   (wr_en),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wen_o   (wen)
  );

  sereep_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/sereep_model_chk.sv
module sereep_model_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic sck_i,
  input logic sdo_o,
  input logic wr_en,
  input logic wen
);
  // R11: with chip select low, data out is 0 one cycle later
  p_sdo_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !sdo_o);

  // R9: no array write reaches the array while the latch is clear
  p_locked_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wen);

  // R4: array writes happen only on a serial clock edge inside a frame
  p_write_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cs_i && sck_i));

  // R3: data out moves only on rising serial clock edges
  p_sdo_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_i) && !$past(sck_i)) |-> $stable(sdo_o));

  // R6: the enable latch moves only on rising serial clock edges
  p_wen_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_i) |-> $stable(wen));
endmodule

bind sereep_model sereep_model_chk u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .cs_i  (cs_i),
  .sck_i (sck_i),
  .sdo_o (sdo_o),
  .wr_en (wr_en),
  .wen   (wen)
);

// File: tb/sereep_model_tb.sv
`timescale 1ns/1ps
module sereep_model_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_i = 1'b0;
  logic sck_i = 1'b0;
  logic sdi_i = 1'b0;
  logic sdo_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  int m_mem [64];
  int m_state = 0;
  int m_cnt = 0;
  int m_hdr = 0;
  int m_sh = 0;
  int m_addr = 0;
  bit m_wen = 1'b0;
  bit m_all = 1'b0;
  logic exp_do = 1'b0;

  always #4 clk = ~clk;

  sereep_model u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i),
    .sck_i(sck_i), .sdi_i(sdi_i), .sdo_o(sdo_o)
  );

  always @(posedge clk) begin
    #2;
    if (mon_en && !done) begin
      checks++;
      if (sdo_o !== exp_do) begin
        errors++;
        $display("FAIL R3 R11 data out per cycle: actual %b expected %b at %0t",
                 sdo_o, exp_do, $time);
      end
    end
  end

  task automatic check_word(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_rise(input logic d);
    case (m_state)
      0: if (d) begin m_state = 1; m_cnt = 0; m_hdr = 0; end
      1: begin
        m_hdr = (m_hdr << 1) | int'(d);
        m_cnt++;
        if (m_cnt == 8) begin
          m_addr = m_hdr & 63;
          m_cnt = 0;
          m_state = 4;
          case ((m_hdr >> 6) & 3)
            2: begin m_sh = m_mem[m_addr]; exp_do = 1'b0; m_state = 2; end
            1: begin m_all = 1'b0; m_state = 3; m_sh = 0; end
            3: if (m_wen) m_mem[m_addr] = 16'hFFFF;
            default: case ((m_hdr >> 4) & 3)
              3: m_wen = 1'b1;
              0: m_wen = 1'b0;
              2: if (m_wen) for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
              default: begin m_all = 1'b1; m_state = 3; m_sh = 0; end
            endcase
          endcase
        end
      end
      2: begin
        exp_do = logic'((m_sh >> 15) & 1);
        m_sh = (m_sh << 1) & 16'hFFFF;
      end
      3: begin
        m_sh = ((m_sh << 1) | int'(d)) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 16) begin
          if (m_wen) begin
            if (m_all) for (int i = 0; i < 64; i++) m_mem[i] = m_sh;
            else m_mem[m_addr] = m_sh;
          end
          m_state = 4;
        end
      end
      default: ;
    endcase
  endtask

  task automatic pulse(input logic d);
    @(negedge clk);
    sdi_i = d;
    sck_i = 1'b1;
    model_rise(d);
    @(negedge clk);
    sck_i = 1'b0;
  endtask

  task automatic open_frame();
    @(negedge clk);
    cs_i = 1'b1;
  endtask

  task automatic close_frame();
    @(negedge clk);
    cs_i = 1'b0;
    sdi_i = 1'b0;
    m_state = 0;
    exp_do = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_head(input int opc, input int adr);
    pulse(1'b1);
    for (int i = 1; i >= 0; i--) pulse(logic'((opc >> i) & 1));
    for (int i = 5; i >= 0; i--) pulse(logic'((adr >> i) & 1));
  endtask

  task automatic send_data(input int val, input int nbits);
    for (int i = 15; i >= 16 - nbits; i--) pulse(logic'((val >> i) & 1));
  endtask

  task automatic do_cmd(input int opc, input int adr, input bit with_data, input int val);
    open_frame();
    send_head(opc, adr);
    if (with_data) send_data(val, 16);
    close_frame();
  endtask

  task automatic read_word(input int adr, input int zeros, input int extra, output int word);
    word = 0;
    open_frame();
    for (int i = 0; i < zeros; i++) pulse(1'b0);
    send_head(2, adr);
    checks++;
    if (sdo_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 dummy bit: actual %b expected 0", sdo_o);
    end
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      word = (word << 1) | int'(sdo_o);
    end
    for (int i = 0; i < extra; i++) pulse(1'b0);
    close_frame();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: erased array and cleared data out after reset
    read_word(0, 0, 0, w);  check_word("R1 word 0", w, 16'hFFFF);
    read_word(63, 0, 0, w); check_word("R1 word 63", w, 16'hFFFF);

    // R9: write with latch clear after reset (R1 latch cleared)
    do_cmd(1, 5, 1'b1, 16'h1357);
    read_word(5, 0, 0, w);  check_word("R9 R1 locked write", w, 16'hFFFF);

    // R6: enable with arbitrary low address bits
    do_cmd(0, 6'b11_1010, 1'b0, 0);
    // R4: single word writes
    do_cmd(1, 5, 1'b1, 16'hA5C3);
    do_cmd(1, 63, 1'b1, 16'h1234);
    read_word(5, 0, 3, w);  check_word("R4 word 5", w, 16'hA5C3);
    read_word(63, 0, 0, w); check_word("R4 word 63", w, 16'h1234);
    // R2: leading zeros before the start bit
    read_word(5, 3, 0, w);  check_word("R2 leading zeros", w, 16'hA5C3);
    // R3: neighbour word untouched
    read_word(4, 0, 0, w);  check_word("R3 word 4", w, 16'hFFFF);

    // R5: erase one word
    do_cmd(3, 5, 1'b0, 0);
    read_word(5, 0, 0, w);  check_word("R5 erased", w, 16'hFFFF);
    read_word(63, 0, 0, w); check_word("R5 other kept", w, 16'h1234);

    // R10: partial write aborted by chip select
    open_frame();
    send_head(1, 7);
    send_data(16'h0000, 10);
    close_frame();
    read_word(7, 0, 0, w);  check_word("R10 partial write", w, 16'hFFFF);
    // R10: abort in the header, next frame still decodes
    open_frame();
    pulse(1'b1); pulse(1'b0);
    close_frame();
    read_word(63, 0, 0, w); check_word("R10 after header abort", w, 16'h1234);

    // R8: write all words
    do_cmd(0, 6'b01_0110, 1'b1, 16'h5A5A);
    read_word(0, 0, 0, w);  check_word("R8 word 0", w, 16'h5A5A);
    read_word(33, 0, 0, w); check_word("R8 word 33", w, 16'h5A5A);

    // R7: erase all words
    do_cmd(0, 6'b10_0001, 1'b0, 0);
    read_word(10, 0, 0, w); check_word("R7 word 10", w, 16'hFFFF);
    do_cmd(1, 20, 1'b1, 16'hBEEF);

    // R6: disable, then every programming command ignored (R9)
    do_cmd(0, 6'b00_1111, 1'b0, 0);
    do_cmd(1, 20, 1'b1, 16'h0F0F);
    do_cmd(3, 20, 1'b0, 0);
    do_cmd(0, 6'b01_0000, 1'b1, 16'h0000);
    do_cmd(0, 6'b10_0000, 1'b0, 0);
    read_word(20, 0, 0, w); check_word("R9 R6 locked word 20", w, 16'hBEEF);
    read_word(21, 0, 0, w); check_word("R9 R7 locked word 21", w, 16'hFFFF);
    read_word(20, 0, 0, w); check_word("R9 model agrees", w, m_mem[20]);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule